// File: doc/BRIEF.md
# Pulse-Count Decimal Multiplier

This block multiplies a three-digit decimal multiplicand by a three-digit decimal multiplier. Both are in BCD, and the block uses repeated addition only. A four-stage reversible BCD counter serves as the accumulator. Each addition of the multiplicand takes one minor cycle of twelve clocks. In the first nine clocks of that cycle every accumulator stage receives, all in parallel, a burst of single-count pulses, one per clock. The number of pulses equals the multiplicand digit aimed at that stage, and the bursts are cut out by fixed clock windows of width 8, 4, 2 and 1. Carries that arise during the bursts are only flagged. They ripple one stage per clock in the last three clocks of the minor cycle.

The multiplier is consumed one digit at a time, least significant first. A four-position digit selector moves only when the addition counter rests at zero. Each time it moves, the addition counter is loaded with ten minus the newly chosen digit. The counter then rises by one per minor cycle until it wraps back to zero. One multiplicand addition happens in every minor cycle in which the counter is nonzero.

Two product modes exist.
- **Modulo mode.** The multiplier is read as an integer and the multiplicand as a fraction 0.xyz. The multiplicand is moved one decade left for each higher multiplier digit, and the accumulator is allowed to overflow. The product is therefore the three fractional digits of the product.
- **High-order mode.** The accumulator is moved one decade right after each multiplier digit, so that only the three leading digits remain.

In modulo mode a negative multiplier makes the stages count down, which subtracts. A negative multiplicand is entered as its complement to 1.000.

Top module: `pc_dec_mul`

## Requirements
- R1: After synchronous reset `done` is 1 and `prod` is 0.
- R2: `start` is taken only in a cycle where `done` is 1. The operands and mode are captured in that cycle, and `done` goes to 0 on the next clock. A `start` while `done` is 0 has no effect on the result or the timing. While idle, `prod` holds its value.
- R3: From the accepting clock edge to the edge that sets `done` takes exactly 12*(4 + sum of the three multiplier digit values) clocks. This covers one 12-clock step cycle for each of the four selector positions and one 12-clock minor cycle for each addition. The selector changes position only in a cycle that follows an addition-counter value of 0, and the counter never exceeds 9.
- R4: Within an addition cycle, a stage receives n count pulses for multiplicand digit value n (0..9), all in clocks 0..8 of the cycle. Digit bits 3, 2, 1 and 0 gate clocks 0..7, 0..3, 4..5 and 8 respectively.
- R5: In modulo mode (`mode_hi`=0) with both signs 0, `prod` = (H*X) mod 1000. H is the multiplier read as an integer and X is the multiplicand read as an integer 0..999.
- R6: In high-order mode (`mode_hi`=1), `prod` = floor(A*S/1000). A is the multiplicand and S is the multiplier, both read as integers 0..999.
- R7: In modulo mode with `mplier_neg`=1, the modulo-mode result is replaced by (1000 - result) mod 1000.
- R8: In modulo mode with `mcand_neg`=1, X is replaced by (1000 - X) mod 1000 before multiplying. R7 applies on top of this when both signs are set.
- R9: In high-order mode `mplier_neg` and `mcand_neg` have no effect on `prod`.
- R10: During a step cycle (addition counter at 0) no counting happens. The accumulator changes only at the last clock of the step cycle, and only by the high-order right shift.
- R11: In clocks 9..11 of an addition cycle the least significant accumulator digit does not change. Carries move one stage per clock in that window, and a carry out of the top stage is dropped.
- R12: A multiplier digit of 0 causes no addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (taken only while done is 1) |
| mode_hi | input | 1 | 0: modulo-1 product, 1: high-order product |
| mcand | input | 12 | Multiplicand, three BCD digits, digit 0 in bits 3:0 |
| mcand_neg | input | 1 | Multiplicand is negative (modulo mode only) |
| mplier | input | 12 | Multiplier, three BCD digits, digit 0 in bits 3:0 |
| mplier_neg | input | 1 | Multiplier is negative (modulo mode only) |
| prod | output | 12 | Three BCD product digits, valid while done is 1 |
| done | output | 1 | Idle and result valid |

## Verification
The assertions take for granted that every digit on `mcand` and `mplier` is a legal BCD value 0..9. The pulse windows of bits 3 and 2 overlap, and they give correct counts only for legal digits, so a code such as 0xC would break the pulse-count, carry and latency properties. The stimulus builds every operand from decimal integers 0..999, converted digit by digit, so no illegal code ever reaches the ports. Signs and mode are drawn freely, including `start` pulses during a busy run.

// File: rtl/pc_dec_mul_pkg.sv
package pc_dec_mul_pkg;

  typedef logic [3:0] bcd_t;

  // Clock positions of the pulse windows inside a minor cycle.
  localparam int W8_END  = 8;  // bit 3 window: clocks 0..7
  localparam int W4_END  = 4;  // bit 2 window: clocks 0..3
  localparam int W2_LO   = 4;  // bit 1 window: clocks 4..5
  localparam int W2_HI   = 5;
  localparam int W1_AT   = 8;  // bit 0 window: clock 8
  localparam int CARRY_BASE = 9; // first carry clock

  // Addition counter preset: ten minus the digit, zero for a zero digit.
  function automatic bcd_t ac_preset(input bcd_t d);
    return (d == 4'd0) ? 4'd0 : 4'(4'd10 - d);
  endfunction

endpackage

// File: rtl/pc_dec_mul_slots.sv
module pc_dec_mul_slots
  import pc_dec_mul_pkg::*;
#(
  parameter int LAST = 11,
  parameter int SW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [SW-1:0] slot,
  output logic          slot_last,
  output logic          w8,
  output logic          w4,
  output logic          w2,
  output logic          w1
);

  always_ff @(posedge clk) begin
    if (rst || !run)      slot <= '0;
    else if (slot_last)   slot <= '0;
    else                  slot <= slot + 1'b1;
  end

  always_comb begin
    slot_last = (slot == SW'(LAST));
    w8 = (slot < SW'(W8_END));
    w4 = (slot < SW'(W4_END));
    w2 = (slot == SW'(W2_LO)) || (slot == SW'(W2_HI));
    w1 = (slot == SW'(W1_AT));
  end

endmodule

// File: rtl/pc_dec_mul_digit.sv
module pc_dec_mul_digit (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       pend_clr,
  input  logic       pulse,
  input  logic       carry_in,
  input  logic       count_dn,
  input  logic       shift_en,
  input  logic [3:0] shift_in,
  output logic [3:0] dig,
  output logic       pend
);

  logic       step;
  logic       wrap;
  logic [3:0] nxt;

  always_comb begin
    step = pulse | carry_in;
    wrap = 1'b0;
    nxt  = dig;
    if (step) begin
      if (count_dn) begin
        if (dig == 4'd0) begin
          nxt  = 4'd9;
          wrap = 1'b1;
        end else begin
          nxt = dig - 4'd1;
        end
      end else begin
        if (dig == 4'd9) begin
          nxt  = 4'd0;
          wrap = 1'b1;
        end else begin
          nxt = dig + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dig  <= 4'd0;
      pend <= 1'b0;
    end else if (shift_en) begin
      dig  <= shift_in;
      pend <= 1'b0;
    end else begin
      dig  <= nxt;
      pend <= (pend & ~pend_clr) | wrap;
    end
  end

endmodule

// File: rtl/pc_dec_mul_seq.sv
module pc_dec_mul_seq
  import pc_dec_mul_pkg::*;
#(
  parameter int NDIG = 3,
  parameter int SELW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              hi,
  input  logic              slot_last,
  input  logic [4*NDIG-1:0] digits,
  output logic              run,
  output logic              done,
  output logic              add_cyc,
  output logic              shift_en,
  output logic [SELW-1:0]   mds,
  output logic [3:0]        ac
);

  bcd_t nxt_dig;

  always_comb begin
    nxt_dig = 4'd0;
    for (int i = 0; i < NDIG; i++) begin
      if (mds == SELW'(i)) nxt_dig = digits[4*i +: 4];
    end
    add_cyc  = run && (ac != 4'd0);
    shift_en = run && slot_last && (ac == 4'd0) && hi && (mds != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b1;
      ac   <= 4'd0;
      mds  <= '0;
    end else if (accept) begin
      run  <= 1'b1;
      done <= 1'b0;
      ac   <= 4'd0;
      mds  <= '0;
    end else if (run && slot_last) begin
      if (ac != 4'd0) begin
        ac <= (ac == 4'd9) ? 4'd0 : ac + 4'd1;
      end else if (mds == SELW'(NDIG)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        mds <= mds + 1'b1;
        ac  <= ac_preset(nxt_dig);
      end
    end
  end

endmodule

// File: rtl/pc_dec_mul.sv
module pc_dec_mul
  import pc_dec_mul_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_hi,
  input  logic [4*NDIG-1:0] mcand,
  input  logic              mcand_neg,
  input  logic [4*NDIG-1:0] mplier,
  input  logic              mplier_neg,
  output logic [4*NDIG-1:0] prod,
  output logic              done
);

  localparam int NST   = NDIG + 1;
  localparam int OPW   = 4 * NDIG;
  localparam int ACW   = 4 * NST;
  localparam int SELW  = $clog2(NDIG + 1);
  localparam int MINOR = CARRY_BASE + NST - 1;
  localparam int SW    = $clog2(MINOR);

  logic [OPW-1:0]  mc_q;
  logic [OPW-1:0]  mp_q;
  logic            dn_q;
  logic            hi_q;
  logic            accept;
  logic            run;
  logic            add_cyc;
  logic            shift_en;
  logic [SELW-1:0] mds;
  logic [3:0]      ac;
  logic [SW-1:0]   slot;
  logic            slot_last;
  logic            w8, w4, w2, w1;
  logic [ACW-1:0]  acc;
  logic [ACW-1:0]  opnd;
  logic [NST-1:0]  pend;
  logic [SELW-1:0] sh_idx;
  logic            unused_carry;

  // Ten's complement of a BCD fraction with respect to 1.000...
  function automatic logic [OPW-1:0] tens_comp(input logic [OPW-1:0] v);
    logic [OPW-1:0] r;
    logic           seen;
    bcd_t           d;
    r    = '0;
    seen = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      d = v[4*i +: 4];
      if (!seen) begin
        if (d != 4'd0) begin
          r[4*i +: 4] = 4'(4'd10 - d);
          seen = 1'b1;
        end
      end else begin
        r[4*i +: 4] = 4'(4'd9 - d);
      end
    end
    return r;
  endfunction

  assign accept = start & done;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
      mp_q <= '0;
      dn_q <= 1'b0;
      hi_q <= 1'b0;
    end else if (accept) begin
      mc_q <= (mcand_neg && !mode_hi) ? tens_comp(mcand) : mcand;
      mp_q <= mplier;
      dn_q <= mplier_neg & ~mode_hi;
      hi_q <= mode_hi;
    end
  end

  // Multiplicand placed under the accumulator: fixed in high-order mode,
  // moved one decade left per multiplier position in modulo mode.
  always_comb begin
    sh_idx = mds - 1'b1;
    if (hi_q) opnd = {4'h0, mc_q};
    else      opnd = {4'h0, mc_q} << {sh_idx, 2'b00};
  end

  pc_dec_mul_slots #(.LAST(MINOR - 1), .SW(SW)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .slot      (slot),
    .slot_last (slot_last),
    .w8        (w8),
    .w4        (w4),
    .w2        (w2),
    .w1        (w1)
  );

  pc_dec_mul_seq #(.NDIG(NDIG), .SELW(SELW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .hi        (hi_q),
    .slot_last (slot_last),
    .digits    (mp_q),
    .run       (run),
    .done      (done),
    .add_cyc   (add_cyc),
    .shift_en  (shift_en),
    .mds       (mds),
    .ac        (ac)
  );

  for (genvar k = 0; k < NST; k++) begin : g_dig
    logic       pls;
    logic       cin;
    logic [3:0] sin;
    bcd_t       od;

    assign od  = opnd[4*k +: 4];
    assign pls = add_cyc & ((od[3] & w8) | (od[2] & w4) | (od[1] & w2) | (od[0] & w1));

    if (k == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_chain
      assign cin = add_cyc & pend[k-1] & (slot == SW'(CARRY_BASE + k - 1));
    end

    if (k == NST - 1) begin : g_top
      assign sin = 4'd0;
    end else begin : g_mid
      assign sin = acc[4*(k+1) +: 4];
    end

    pc_dec_mul_digit u_digit (
      .clk      (clk),
      .rst      (rst),
      .clr      (accept),
      .pend_clr (slot == '0),
      .pulse    (pls),
      .carry_in (cin),
      .count_dn (dn_q),
      .shift_en (shift_en),
      .shift_in (sin),
      .dig      (acc[4*k +: 4]),
      .pend     (pend[k])
    );
  end

  assign unused_carry = pend[NST-1];
  assign prod = acc[OPW-1:0];

endmodule

// File: rtl/pc_dec_mul_chk.sv
module pc_dec_mul_chk #(
  parameter int NDIG = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  done,
  input logic                  run,
  input logic [$clog2(NDIG+9)-1:0] slot,
  input logic [3:0]            ac,
  input logic [$clog2(NDIG+1)-1:0] mds,
  input logic [4*(NDIG+1)-1:0] acc
);

  localparam int CB    = 9;
  localparam int LAST  = CB + NDIG - 1;
  localparam int SW    = $clog2(NDIG + 9);

  p_accept_drops_done_r2: assert property (@(posedge clk) disable iff (rst)
    (start && done) |=> !done);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(acc)));

  p_ac_range_r3: assert property (@(posedge clk) disable iff (rst)
    ac <= 4'd9);

  p_sel_moves_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mds) |-> ($past(ac) == 4'd0));

  p_step_no_count_r10: assert property (@(posedge clk) disable iff (rst)
    (run && (ac == 4'd0) && (slot != SW'(LAST))) |=> $stable(acc));

  p_carry_deferred_r11: assert property (@(posedge clk) disable iff (rst)
    (run && (ac != 4'd0) && (slot >= SW'(CB))) |=> $stable(acc[3:0]));

endmodule

bind pc_dec_mul pc_dec_mul_chk #(.NDIG(NDIG)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .run   (run),
  .slot  (slot),
  .ac    (ac),
  .mds   (mds),
  .acc   (acc)
);

// File: tb/pc_dec_mul_tb.sv
`timescale 1ns/1ps
module pc_dec_mul_tb;

  localparam int NDIG  = 3;
  localparam int MODV  = 1000;
  localparam int MINOR = 9 + NDIG;

  logic              clk;
  logic              rst;
  logic              start;
  logic              mode_hi;
  logic [4*NDIG-1:0] mcand;
  logic              mcand_neg;
  logic [4*NDIG-1:0] mplier;
  logic              mplier_neg;
  logic [4*NDIG-1:0] prod;
  logic              done;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  pc_dec_mul #(.NDIG(NDIG)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode_hi    (mode_hi),
    .mcand      (mcand),
    .mcand_neg  (mcand_neg),
    .mplier     (mplier),
    .mplier_neg (mplier_neg),
    .prod       (prod),
    .done       (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R3 watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int bcd2int(input logic [4*NDIG-1:0] b);
    int v = 0;
    for (int i = NDIG - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [4*NDIG-1:0] int2bcd(input int x);
    logic [4*NDIG-1:0] r = '0;
    int v = x;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int exp_mod(input int h, input bit hn, input int x, input bit xn);
    int xv = xn ? (MODV - x) % MODV : x;
    int p  = (h * xv) % MODV;
    if (hn) p = (MODV - p) % MODV;
    return p;
  endfunction

  function automatic int exp_hi(input int a, input int s);
    return (a * s) / MODV;
  endfunction

  function automatic int exp_lat(input int h);
    int s = 0;
    int v = h;
    for (int i = 0; i < NDIG; i++) begin
      s = s + v % 10;
      v = v / 10;
    end
    return MINOR * (NDIG + 1 + s);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks = checks + 1;
    if (act != expv) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_op(input bit hi, input int h, input bit hn, input int x, input bit xn,
                       output int p, output int lat);
    int n;
    while (!done) @(negedge clk);
    mode_hi    = hi;
    mplier     = int2bcd(h);
    mplier_neg = hn;
    mcand      = int2bcd(x);
    mcand_neg  = xn;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    p   = bcd2int(prod);
    lat = n - 1;
  endtask

  task automatic run_chk(input bit hi, input int h, input bit hn, input int x, input bit xn,
                         input string req);
    int p, lat, e;
    do_op(hi, h, hn, x, xn, p, lat);
    e = hi ? exp_hi(x, h) : exp_mod(h, hn, x, xn);
    chk(req, p, e);
    chk("R3 latency", lat, exp_lat(h));
  endtask

  initial begin
    int p, lat, n, hold;
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; mode_hi = 1'b0;
    mcand = '0; mcand_neg = 1'b0; mplier = '0; mplier_neg = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 1);
    chk("R1 prod after reset", bcd2int(prod), 0);

    run_chk(1'b0, 123, 1'b0, 456, 1'b0, "R5 modulo 123x0.456");
    run_chk(1'b0, 999, 1'b0, 999, 1'b0, "R4 R11 modulo all nines");
    run_chk(1'b1, 999, 1'b0, 999, 1'b0, "R4 R6 R10 high all nines");
    run_chk(1'b0, 0, 1'b0, 777, 1'b0, "R12 zero multiplier");
    run_chk(1'b0, 808, 1'b0, 345, 1'b0, "R12 inner zero digit");
    run_chk(1'b0, 7, 1'b1, 250, 1'b0, "R7 negative multiplier");
    run_chk(1'b0, 2, 1'b0, 1, 1'b1, "R8 negative multiplicand");
    run_chk(1'b0, 3, 1'b1, 100, 1'b1, "R7 R8 both negative");
    run_chk(1'b1, 250, 1'b0, 500, 1'b0, "R6 R10 high 5.00x0.250");
    run_chk(1'b1, 250, 1'b1, 500, 1'b1, "R9 high ignores signs");

    // R2: idle prod holds while inputs move
    hold = bcd2int(prod);
    mcand = int2bcd(111); mplier = int2bcd(222); mode_hi = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 idle prod holds", bcd2int(prod), hold);

    // R2: start during a busy run is ignored
    mode_hi = 1'b0; mplier = int2bcd(5); mplier_neg = 1'b0;
    mcand = int2bcd(111); mcand_neg = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done low after accept", int'(done), 0);
    n = 1;
    repeat (20) begin @(negedge clk); n++; end
    mplier = int2bcd(999); mcand = int2bcd(999); start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk("R2 busy start ignored prod", bcd2int(prod), 555);
    chk("R2 R3 busy start latency", n - 1, exp_lat(5));

    // constrained random mix
    for (int t = 0; t < 80; t++) begin
      bit hi, hn, xn;
      int h, x;
      hi = 1'($urandom % 2);
      hn = 1'($urandom % 2);
      xn = 1'($urandom % 2);
      h  = int'($urandom % 1000);
      x  = int'($urandom % 1000);
      run_chk(hi, h, hn, x, xn, hi ? "R6 R9 random high" : "R5 R7 R8 random modulo");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule